// File: doc/BRIEF.md
# ID-Stage Branch Resolver

This block holds the fetch address and the fetch-to-decode pipeline register of a five-stage integer pipeline. It picks the address of the next fetch. Fetch always runs ahead on the sequential path, at the current address plus four. When a conditional branch or a jump reaches decode, its outcome is settled in that same stage.

Conditional branches are resolved by testing the two operand values from the register file for equality. Jumps are always taken. On a redirect the block steers the fetch address to the computed target and discards the one instruction fetched behind the control instruction. That slot is replaced with an all-zero no-op, so each redirect costs exactly one cycle.

The caller supplies the fetched instruction word for the current fetch address. It also supplies the two register values indexed by the source fields of the instruction now in decode. The block returns the fetch address, the contents of the decode register, the next address, the source select and the flush strobe.

Top module: `bru_top`

## Requirements
- R1: While reset is low, the fetch address equals the `RESET_PC` parameter, the decode instruction and decode return address are zero, and flush is low.
- R2: When the opcode (bits 31:26) of the decode instruction is anything other than 2, 4 or 5, next_pc equals fetch_pc + 4, pc_sel is 0 (sequential) and flush is low.
- R3: Opcode 4 is taken exactly when the register value for bits 25:21 equals the register value for bits 20:16.
- R4: Opcode 5 is taken exactly when those two register values differ, including when they differ only in the top bit.
- R5: A taken conditional branch sets pc_sel to 1. It sets next_pc to the decode return address plus the sign-extended 16-bit offset (bits 15:0) shifted left by two.
- R6: Opcode 2 is always taken. It sets pc_sel to 2 and next_pc to the top 4 bits of the decode return address, followed by bits 25:0 of the instruction, followed by two zero bits.
- R7: Flush is high exactly when a branch is taken or a jump is decoded. On the next cycle the decode instruction and decode return address are both zero, so a control instruction in the discarded slot has no effect.
- R8: Without a flush, the decode register captures the fetched word and fetch_pc + 4 at each clock.
- R9: The fetch address takes the value of next_pc at every clock after reset.
- R10: next_pc always has its two least significant bits at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_instr | input | 32 | Instruction word read at fetch_pc |
| rd_a | input | 32 | Register value selected by decode bits 25:21 |
| rd_b | input | 32 | Register value selected by decode bits 20:16 |
| fetch_pc | output | 32 | Current fetch address |
| ifid_instr | output | 32 | Instruction held in the decode register |
| ifid_pc4 | output | 32 | Return address (fetch address + 4) held with it |
| next_pc | output | 32 | Address loaded into fetch_pc at the next clock |
| pc_sel | output | 2 | Source of next_pc: 0 sequential, 1 branch, 2 jump |
| flush | output | 1 | Discard the instruction fetched this cycle |

## Verification
The program places a jump in the slot right behind a taken branch. A design that failed to discard that slot would follow the jump and leave the reference trace at once.

A backward branch with a negative offset catches a missing sign extension, which would send the fetch far forward. A fetch region with a non-zero top nibble shows whether the jump keeps the upper bits of the return address.

A not-equal test on operands that differ only in bit 31 exposes a narrow comparator. A load-opcode word whose fields look like a branch shows whether decoding is too loose.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam logic [5:0] OPC_JUMP = 6'd2;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_BNE  = 6'd5;

    typedef enum logic [1:0] {
        SEL_SEQ  = 2'd0,
        SEL_BR   = 2'd1,
        SEL_JUMP = 2'd2
    } pc_sel_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_BEQ  = 2'd1,
        KIND_BNE  = 2'd2,
        KIND_JUMP = 2'd3
    } ctl_kind_e;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic [OPC_W-1:0] opcode,
    output ctl_kind_e        kind
);

    always_comb begin
        kind = KIND_NONE;
        if (opcode == OPC_W'(OPC_BEQ)) begin
            kind = KIND_BEQ;
        end else if (opcode == OPC_W'(OPC_BNE)) begin
            kind = KIND_BNE;
        end else if (opcode == OPC_W'(OPC_JUMP)) begin
            kind = KIND_JUMP;
        end
    end

endmodule

// File: rtl/bru_compare.sv
module bru_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              same
);

    logic [DATA_W-1:0] diff;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign diff[i] = lhs[i] ^ rhs[i];
    end

    assign same = ~|diff;

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 16,
    parameter int JIDX_W  = 26,
    parameter int ALIGN_W = 2
) (
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [JIDX_W-1:0] jump_idx,
    output logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] jump_target
);

    localparam int EXT_W    = ADDR_W - OFF_W - ALIGN_W;
    localparam int REGION_W = ADDR_W - JIDX_W - ALIGN_W;

    logic [ADDR_W-1:0] off_scaled;

    assign off_scaled  = {{EXT_W{br_off[OFF_W-1]}}, br_off, {ALIGN_W{1'b0}}};
    assign br_target   = ret_addr + off_scaled;
    assign jump_target = {ret_addr[ADDR_W-1 -: REGION_W], jump_idx, {ALIGN_W{1'b0}}};

endmodule

// File: rtl/bru_top.sv
module bru_top
    import bru_pkg::*;
#(
    parameter int          INSTR_W  = 32,
    parameter int          OPC_W    = 6,
    parameter int          RIDX_W   = 5,
    parameter int          OFF_W    = 16,
    parameter int          JIDX_W   = 26,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_instr,
    input  logic [INSTR_W-1:0] rd_a,
    input  logic [INSTR_W-1:0] rd_b,
    output logic [INSTR_W-1:0] fetch_pc,
    output logic [INSTR_W-1:0] ifid_instr,
    output logic [INSTR_W-1:0] ifid_pc4,
    output logic [INSTR_W-1:0] next_pc,
    output logic [1:0]         pc_sel,
    output logic               flush
);

    localparam int                 WORD_BYTES = INSTR_W / 8;
    localparam int                 ALIGN_W    = $clog2(WORD_BYTES);
    localparam int                 OPC_LSB    = INSTR_W - OPC_W;
    localparam logic [INSTR_W-1:0] PC_STEP    = INSTR_W'(WORD_BYTES);

    typedef struct packed {
        logic [INSTR_W-1:0] pc;
        logic [INSTR_W-1:0] instr;
        logic [INSTR_W-1:0] pc4;
    } fe_state_t;

    fe_state_t          st_d, st_q;
    ctl_kind_e          kind;
    logic               ops_same;
    logic [INSTR_W-1:0] br_tgt, jmp_tgt;
    logic [INSTR_W-1:0] seq_pc, npc;
    pc_sel_e            sel;
    logic               redirect;

    bru_decode #(.OPC_W(OPC_W)) u_dec (
        .opcode (st_q.instr[INSTR_W-1 -: OPC_W]),
        .kind   (kind)
    );

    bru_compare #(.DATA_W(INSTR_W)) u_cmp (
        .lhs  (rd_a),
        .rhs  (rd_b),
        .same (ops_same)
    );

    bru_target #(
        .ADDR_W  (INSTR_W),
        .OFF_W   (OFF_W),
        .JIDX_W  (JIDX_W),
        .ALIGN_W (ALIGN_W)
    ) u_tgt (
        .ret_addr    (st_q.pc4),
        .br_off      (st_q.instr[OFF_W-1:0]),
        .jump_idx    (st_q.instr[JIDX_W-1:0]),
        .br_target   (br_tgt),
        .jump_target (jmp_tgt)
    );

    always_comb begin
        seq_pc   = st_q.pc + PC_STEP;
        sel      = SEL_SEQ;
        npc      = seq_pc;
        redirect = 1'b0;
        unique case (kind)
            KIND_BEQ: if (ops_same) begin
                sel = SEL_BR; npc = br_tgt; redirect = 1'b1;
            end
            KIND_BNE: if (!ops_same) begin
                sel = SEL_BR; npc = br_tgt; redirect = 1'b1;
            end
            KIND_JUMP: begin
                sel = SEL_JUMP; npc = jmp_tgt; redirect = 1'b1;
            end
            default: ;
        endcase

        st_d    = st_q;
        st_d.pc = npc;
        if (redirect) begin
            st_d.instr = '0;
            st_d.pc4   = '0;
        end else begin
            st_d.instr = fetch_instr;
            st_d.pc4   = seq_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc    <= INSTR_W'(RESET_PC);
            st_q.instr <= '0;
            st_q.pc4   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc   = st_q.pc;
    assign ifid_instr = st_q.instr;
    assign ifid_pc4   = st_q.pc4;
    assign next_pc    = npc;
    assign pc_sel     = sel;
    assign flush      = redirect;

    // The register-index fields are consumed by the register file outside this block.
    localparam int RIDX_SPAN = 2 * RIDX_W;
    if (OPC_LSB < RIDX_SPAN) begin : g_bad_fields
        initial $error("opcode field overlaps register index fields");
    end

endmodule

// File: rtl/bru_chk.sv
module bru_chk #(
    parameter int INSTR_W = 32,
    parameter int OPC_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] fetch_instr,
    input logic [INSTR_W-1:0] fetch_pc,
    input logic [INSTR_W-1:0] ifid_instr,
    input logic [INSTR_W-1:0] ifid_pc4,
    input logic [INSTR_W-1:0] next_pc,
    input logic [1:0]         pc_sel,
    input logic               flush
);

    localparam logic [INSTR_W-1:0] STEP = INSTR_W'(INSTR_W / 8);

    // R7
    flush_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ifid_instr == '0 && ifid_pc4 == '0));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (ifid_instr == $past(fetch_instr) && ifid_pc4 == $past(fetch_pc) + STEP));

    // R9
    pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fetch_pc == $past(next_pc)));

    // R10
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc[1:0] == 2'b00);

    // R2
    seq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (next_pc == fetch_pc + STEP && pc_sel == 2'd0));

    // R6
    jump_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_instr[INSTR_W-1 -: OPC_W] == OPC_W'(2)) |-> (flush && pc_sel == 2'd2));

endmodule

bind bru_top bru_chk #(.INSTR_W(INSTR_W), .OPC_W(OPC_W)) u_bru_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_instr (fetch_instr),
    .fetch_pc    (fetch_pc),
    .ifid_instr  (ifid_instr),
    .ifid_pc4    (ifid_pc4),
    .next_pc     (next_pc),
    .pc_sel      (pc_sel),
    .flush       (flush)
);

// File: tb/tb_bru_top.sv
`timescale 1ns/1ps
module tb_bru_top;

    localparam logic [31:0] BASE = 32'h3000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_instr, rd_a, rd_b;
    logic [31:0] fetch_pc, ifid_instr, ifid_pc4, next_pc;
    logic [1:0]  pc_sel;
    logic        flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bru_top #(.RESET_PC(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
        .rd_a(rd_a), .rd_b(rd_b), .fetch_pc(fetch_pc),
        .ifid_instr(ifid_instr), .ifid_pc4(ifid_pc4),
        .next_pc(next_pc), .pc_sel(pc_sel), .flush(flush)
    );

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int off);
        return {op[5:0], rs[4:0], rt[4:0], off[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(int idx);
        return {6'd2, idx[25:0]};
    endfunction

    function automatic logic [31:0] regval(logic [4:0] idx);
        case (idx)
            5'd0:    return 32'h0;
            5'd1:    return 32'd5;
            5'd2:    return 32'd5;
            5'd3:    return 32'd7;
            5'd5:    return 32'h8000_0005;
            default: return {27'd0, idx} * 3;
        endcase
    endfunction

    function automatic logic [31:0] prog(logic [31:0] addr);
        case (addr - BASE)
            32'h04:  return enc_i(4, 1, 2, 3);
            32'h08:  return enc_j(0);
            32'h0C:  return enc_i(4, 1, 3, 9);
            32'h10:  return enc_j(32'h40);
            32'h14:  return enc_i(5, 1, 2, 5);
            32'h18:  return enc_i(35, 1, 1, 8);
            32'h1C:  return enc_i(5, 1, 3, -5);
            32'h20:  return enc_j(7);
            32'h100: return enc_i(5, 1, 5, -1);
            32'h104: return enc_j(1);
            default: return {6'd0, 5'd1, 5'd2, 5'd4, 5'd0, 6'd32};
        endcase
    endfunction

    always_comb begin
        fetch_instr = prog(fetch_pc);
        rd_a = regval(ifid_instr[25:21]);
        rd_b = regval(ifid_instr[20:16]);
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin
        logic [31:0] m_pc, m_ir, m_p4;
        m_pc = BASE; m_ir = 0; m_p4 = 0;
        repeat (3) @(negedge clk);
        chk("R1", "fetch_pc", fetch_pc, BASE);
        chk("R1", "ifid_instr", ifid_instr, 0);
        chk("R1", "ifid_pc4", ifid_pc4, 0);
        chk("R1", "flush", {31'd0, flush}, 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 80; cyc++) begin
            logic [5:0]  op;
            logic [31:0] a, b, e_npc, off_ext;
            logic [1:0]  e_sel;
            logic        e_fl;
            string       tag, itag;
            op = m_ir[31:26];
            a  = regval(m_ir[25:21]);
            b  = regval(m_ir[20:16]);
            off_ext = {{14{m_ir[15]}}, m_ir[15:0], 2'b00};
            e_npc = m_pc + 4; e_sel = 0; e_fl = 0; tag = "R2";
            if (op == 6'd4) begin
                tag = "R3";
                if (a == b) begin e_npc = m_p4 + off_ext; e_sel = 1; e_fl = 1; tag = "R5"; end
            end else if (op == 6'd5) begin
                tag = "R4";
                if (a != b) begin e_npc = m_p4 + off_ext; e_sel = 1; e_fl = 1; tag = "R5"; end
            end else if (op == 6'd2) begin
                tag = "R6";
                e_npc = {m_p4[31:28], m_ir[25:0], 2'b00}; e_sel = 2; e_fl = 1;
            end
            itag = (m_ir == 0 && m_p4 == 0) ? "R7" : "R8";
            chk("R9", "fetch_pc", fetch_pc, m_pc);
            chk(itag, "ifid_instr", ifid_instr, m_ir);
            chk(itag, "ifid_pc4", ifid_pc4, m_p4);
            chk(tag, "next_pc", next_pc, e_npc);
            chk(tag, "pc_sel", {30'd0, pc_sel}, {30'd0, e_sel});
            chk("R7", "flush", {31'd0, flush}, {31'd0, e_fl});
            chk("R10", "next_pc align", {30'd0, next_pc[1:0]}, 0);
            m_ir = e_fl ? 32'h0 : prog(m_pc);
            m_p4 = e_fl ? 32'h0 : m_pc + 4;
            m_pc = e_npc;
            @(negedge clk);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule